// File: doc/BRIEF.md
# I2C Bit-Rate Divider with Prescaler

This block sets up the clock timing for an I2C master. Software or a controller gives it the system clock frequency and the wanted SCL frequency, both in hertz, and pulses a configuration request. The block then runs a short sequence over several clock cycles:

- It divides half the system clock by the SCL frequency, using a sequential restoring divider.
- It takes 8 away from the quotient.
- It reduces the result until it fits an 8-bit divisor. Each reduction step shifts the value right by four bits and raises a prescaler count by one.

When the sequence ends, the block loads the divisor and prescaler fields and keeps them until the next request. It also raises a single-cycle done pulse. From that point a tick generator divides the system clock into the two equal halves of the SCL period, and the bit engine uses these ticks as its timing enable. If the wanted rate is too low for a two-bit prescaler, the block raises a flag and sends no ticks.

Top module: `i2c_rate_cfg`

## Requirements
- R1: The first divisor value is floor(floor(sys_hz/2)/scl_hz) minus 8. If the quotient is below 8, the value saturates at 0.
- R2: While the divisor value is above 255, the block shifts it right by four bits and adds one to a prescaler count that starts at 0.
- R3: `cfg_div` is the low 8 bits of the final value. `cfg_pre` is the low 2 bits of the final prescaler count.
- R4: `rate_too_low` is 1 when the final prescaler count is greater than 3. While it is 1, `scl_tick` stays 0 and `scl_phase` stays 1.
- R5: `cfg_done` is high for exactly one cycle, in the same cycle that `cfg_valid` rises. After that, `cfg_valid`, `cfg_div` and `cfg_pre` hold their values until the next `cfg_req`.
- R6: With a valid configuration that is not too low, `scl_tick` pulses every H = 8 + cfg_div·4^cfg_pre clocks. The first pulse comes H clocks after `cfg_done`. The full SCL period is therefore 2·H clocks.
- R7: `scl_phase` toggles in each cycle where `scl_tick` is high, so the SCL low and high halves are equal. It is 1 while no valid configuration drives the ticks.
- R8: A `cfg_req` in any state starts a new computation from the inputs present in that cycle. `cfg_valid` is 0 in the next cycle, and only the latest request produces a result.
- R9: After reset, `cfg_valid`, `cfg_done`, `rate_too_low` and `scl_tick` are 0, and `scl_phase` is 1.
- R10: An `scl_hz` of 0 gives an all-ones quotient, and the block reports it as too low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req | input | 1 | Single-cycle request to compute a new configuration |
| sys_hz | input | 32 | System clock frequency in Hz, sampled with `cfg_req` |
| scl_hz | input | 32 | Wanted SCL frequency in Hz, sampled with `cfg_req` |
| cfg_done | output | 1 | Single-cycle pulse when a new configuration is loaded |
| cfg_valid | output | 1 | The configuration fields are valid |
| rate_too_low | output | 1 | The wanted rate needs a prescaler above 3 |
| cfg_div | output | 8 | Bit-rate divisor |
| cfg_pre | output | 2 | Prescaler, giving a factor of 4^cfg_pre |
| scl_tick | output | 1 | Half-period timing enable for the bit engine |
| scl_phase | output | 1 | SCL half indicator, toggling on each tick |

## Verification
The assertions check the cycle-level rules on every cycle:

- `cfg_done` is a single pulse that coincides with `cfg_valid`.
- The fields stay stable while no request arrives.
- A request clears `cfg_valid`.
- No tick appears while the rate is too low.
- Ticks are never back to back.
- `scl_phase` flips on each tick.

Only the bench scenarios can show the arithmetic: the subtract-and-saturate step, the exact stopping point of the reduction loop at 255 and 256, the truncation of the prescaler count, and the exact spacing of ticks for each configuration. The bench compares each of these against its own model of the formula. It also covers a request that arrives while a computation is in progress.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

    // Configuration sequencer states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_NORM
    } cfg_st_e;

    // Constant added to every half period
    localparam int unsigned HALF_BASE  = 8;
    // Offset taken off the quotient
    localparam int unsigned SUB_OFFSET = 8;
    // Right shift applied per prescaler step
    localparam int unsigned NORM_SHIFT = 4;

endpackage

// File: rtl/i2c_rate_divu.sv
// Sequential restoring divider: one quotient bit per cycle.
module i2c_rate_divu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dsr;
    } div_t;

    div_t q, d;
    logic [W:0] rem_sh;
    logic [W:0] diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem, q.quo[W-1]};
        diff   = rem_sh - {1'b0, q.dsr};
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(W);
            d.rem  = '0;
            d.quo  = dividend;
            d.dsr  = divisor;
        end else if (q.busy) begin
            if (!diff[W]) begin
                d.rem = diff[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = rem_sh[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign quotient = q.quo;
endmodule

// File: rtl/i2c_rate_tick.sv
// Half-period tick generator: H = HALF_BASE + div * 4^pre.
module i2c_rate_tick
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic [PRE_W-1:0] pre,
    output logic             tick,
    output logic             phase
);
    localparam int HALF_W = DIV_W + 2 * (2**PRE_W - 1) + 1;

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              tick;
        logic              phase;
    } tick_t;

    tick_t q, d;
    logic [HALF_W-1:0] half;

    always_comb begin
        half = HALF_W'(HALF_BASE) + (HALF_W'(div) << {pre, 1'b0});
        d    = q;
        if (!en) begin
            d.cnt   = '0;
            d.tick  = 1'b0;
            d.phase = 1'b1;
        end else if (q.cnt == half - 1'b1) begin
            d.cnt   = '0;
            d.tick  = 1'b1;
            d.phase = ~q.phase;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tick  = q.tick;
    assign phase = q.phase;
endmodule

// File: rtl/i2c_rate_cfg.sv
module i2c_rate_cfg
    import i2c_rate_pkg::*;
#(
    parameter int HZ_W  = 32,
    parameter int DIV_W = 8,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_req,
    input  logic [HZ_W-1:0]  sys_hz,
    input  logic [HZ_W-1:0]  scl_hz,
    output logic             cfg_done,
    output logic             cfg_valid,
    output logic             rate_too_low,
    output logic [DIV_W-1:0] cfg_div,
    output logic [PRE_W-1:0] cfg_pre,
    output logic             scl_tick,
    output logic             scl_phase
);
    // Widest prescaler count reachable by reducing an HZ_W-bit value
    localparam int PCNT_W = $clog2((HZ_W - DIV_W) / NORM_SHIFT + 2);
    localparam logic [HZ_W-1:0]   DIV_MAX = {{(HZ_W-DIV_W){1'b0}}, {DIV_W{1'b1}}};
    localparam logic [PCNT_W-1:0] PRE_MAX = PCNT_W'(2**PRE_W - 1);

    typedef struct packed {
        cfg_st_e           st;
        logic [HZ_W-1:0]   val;
        logic [PCNT_W-1:0] pcnt;
        logic [DIV_W-1:0]  div;
        logic [PRE_W-1:0]  pre;
        logic              low;
        logic              valid;
        logic              done;
    } cfg_t;

    cfg_t q, d;
    logic            div_done;
    logic [HZ_W-1:0] div_quo;

    i2c_rate_divu #(.W(HZ_W)) u_divu (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cfg_req),
        .dividend (sys_hz >> 1),
        .divisor  (scl_hz),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cfg_req) begin
            d.st    = ST_DIVIDE;
            d.valid = 1'b0;
            d.low   = 1'b0;
        end else begin
            unique case (q.st)
                ST_DIVIDE: begin
                    if (div_done) begin
                        d.val  = (div_quo < HZ_W'(SUB_OFFSET)) ? '0
                                                               : div_quo - HZ_W'(SUB_OFFSET);
                        d.pcnt = '0;
                        d.st   = ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (q.val > DIV_MAX) begin
                        d.val  = q.val >> NORM_SHIFT;
                        d.pcnt = q.pcnt + 1'b1;
                    end else begin
                        d.div   = q.val[DIV_W-1:0];
                        d.pre   = q.pcnt[PRE_W-1:0];
                        d.low   = (q.pcnt > PRE_MAX);
                        d.valid = 1'b1;
                        d.done  = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    i2c_rate_tick #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.valid && !q.low),
        .div   (q.div),
        .pre   (q.pre),
        .tick  (scl_tick),
        .phase (scl_phase)
    );

    assign cfg_done     = q.done;
    assign cfg_valid    = q.valid;
    assign rate_too_low = q.low;
    assign cfg_div      = q.div;
    assign cfg_pre      = q.pre;
endmodule

// File: rtl/i2c_rate_cfg_chk.sv
module i2c_rate_cfg_chk #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_req,
    input logic             cfg_done,
    input logic             cfg_valid,
    input logic             rate_too_low,
    input logic [DIV_W-1:0] cfg_div,
    input logic [PRE_W-1:0] cfg_pre,
    input logic             scl_tick,
    input logic             scl_phase
);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);

    a_r5_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> cfg_valid);

    a_r5_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_req) |=> (cfg_valid && $stable(cfg_div) && $stable(cfg_pre)));

    a_r8_req_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> !cfg_valid);

    a_r4_no_tick_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        rate_too_low |-> (!scl_tick && scl_phase));

    a_r6_ticks_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |=> !scl_tick);

    a_r7_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |-> (scl_phase != $past(scl_phase)));
endmodule

bind i2c_rate_cfg i2c_rate_cfg_chk #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_req      (cfg_req),
    .cfg_done     (cfg_done),
    .cfg_valid    (cfg_valid),
    .rate_too_low (rate_too_low),
    .cfg_div      (cfg_div),
    .cfg_pre      (cfg_pre),
    .scl_tick     (scl_tick),
    .scl_phase    (scl_phase)
);

// File: tb/i2c_rate_cfg_test.sv
`timescale 1ns/1ps
module i2c_rate_cfg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic [31:0] sys_hz = '0;
    logic [31:0] scl_hz = '0;
    logic        cfg_done, cfg_valid, rate_too_low, scl_tick, scl_phase;
    logic [7:0]  cfg_div;
    logic [1:0]  cfg_pre;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    i2c_rate_cfg uut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .sys_hz(sys_hz), .scl_hz(scl_hz),
        .cfg_done(cfg_done), .cfg_valid(cfg_valid), .rate_too_low(rate_too_low),
        .cfg_div(cfg_div), .cfg_pre(cfg_pre), .scl_tick(scl_tick), .scl_phase(scl_phase)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model of the formula
    task automatic model(input logic [31:0] s, input logic [31:0] f,
                         output int dv, output int pr, output bit low, output int half);
        longint qv;
        int p;
        if (f == 0) qv = 64'h0000_0000_FFFF_FFFF;
        else        qv = longint'(s >> 1) / longint'(f);
        qv = (qv < 8) ? 0 : qv - 8;
        p = 0;
        while (qv > 255) begin
            qv = qv >> 4;
            p++;
        end
        dv   = int'(qv & 255);
        pr   = p & 3;
        low  = (p > 3);
        half = 8 + (dv << (2 * pr));
    endtask

    task automatic request(input logic [31:0] s, input logic [31:0] f);
        @(negedge clk);
        sys_hz  = s;
        scl_hz  = f;
        cfg_req = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (cfg_done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, req, 0, 1);
    endtask

    // Full scenario: request, compare fields, then measure tick spacing
    task automatic run_case(input logic [31:0] s, input logic [31:0] f, input string tag);
        int dv, pr, half, n;
        bit low, seen;
        model(s, f, dv, pr, low, half);
        request(s, f);
        wait_done({tag, " R5 done"}, seen);
        if (!seen) return;
        chk(cfg_valid == 1'b1, {tag, " R5 valid"}, cfg_valid, 1);
        chk(cfg_div == dv[7:0], {tag, " R1 R2 R3 div"}, cfg_div, dv);
        chk(cfg_pre == pr[1:0], {tag, " R2 R3 pre"}, cfg_pre, pr);
        chk(rate_too_low == low, {tag, " R4 too_low"}, rate_too_low, low);
        @(negedge clk);
        chk(cfg_done == 1'b0, {tag, " R5 done single"}, cfg_done, 0);
        if (low) begin
            n = 0;
            for (int i = 0; i < 400; i++) begin
                if (scl_tick || !scl_phase) n++;
                @(negedge clk);
            end
            chk(n == 0, {tag, " R4 no ticks"}, n, 0);
        end else begin
            // First tick H clocks after done (one clock already elapsed)
            n = 1;
            while (!scl_tick && n < 20000) begin
                @(negedge clk);
                n++;
            end
            chk(n == half, {tag, " R6 first tick"}, n, half);
            for (int k = 0; k < 2; k++) begin
                logic ph0;
                ph0 = scl_phase;
                n = 0;
                do begin
                    @(negedge clk);
                    n++;
                end while (!scl_tick && n < 20000);
                chk(n == half, {tag, " R6 tick spacing"}, n, half);
                chk(scl_phase == ~ph0, {tag, " R7 phase toggle"}, scl_phase, ~ph0);
            end
            chk(cfg_valid && cfg_div == dv[7:0], {tag, " R5 held"}, cfg_div, dv);
        end
    endtask

    task automatic t_reset;
        chk(cfg_valid == 0, "R9 valid", cfg_valid, 0);
        chk(cfg_done == 0, "R9 done", cfg_done, 0);
        chk(rate_too_low == 0, "R9 too_low", rate_too_low, 0);
        chk(scl_tick == 0, "R9 tick", scl_tick, 0);
        chk(scl_phase == 1, "R9 phase", scl_phase, 1);
    endtask

    task automatic t_restart;
        int dv, pr, half;
        bit low, seen;
        model(32'd100_000_000, 32'd400_000, dv, pr, low, half);
        request(32'd100_000_000, 32'd1);
        chk(cfg_valid == 0, "R8 valid cleared", cfg_valid, 0);
        repeat (5) @(negedge clk);
        request(32'd100_000_000, 32'd400_000);
        wait_done("R8 restart done", seen);
        if (seen) begin
            chk(cfg_div == dv[7:0], "R8 latest div", cfg_div, dv);
            chk(cfg_pre == pr[1:0], "R8 latest pre", cfg_pre, pr);
            chk(rate_too_low == 0, "R8 latest low", rate_too_low, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_case(32'd100_000_000, 32'd100_000, "R2 100k");
        run_case(32'd100_000_000, 32'd400_000, "R1 400k");
        run_case(32'd100_000_000, 32'd10_000, "R2 10k two steps");
        run_case(32'd100_000_000, 32'd20_000_000, "R1 saturate");
        run_case(32'd526_000, 32'd1_000, "R2 edge 255");
        run_case(32'd528_000, 32'd1_000, "R2 edge 256");
        run_case(32'd100_000_000, 32'd1, "R4 1Hz");
        run_case(32'd100_000_000, 32'd0, "R10 zero");
        t_restart();
        run_case(32'd16_000_000, 32'd100_000, "R6 16MHz");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule